// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar that another block keeps and raises an interrupt when the time reaches a programmed alarm point. Software programs six alarm fields (second, minute, hour, day, month and year) in BCD, picks which of them take part in the comparison, and sets a master enable. Each time the calendar advances by one second, the block compares the enabled fields with the current BCD calendar values it is given. If any one enabled field is equal, the alarm fires.

A firing alarm sets a sticky pending flag, which drives a level-sensitive interrupt line. The flag stays set until software writes a 1 to its bit in the pending register. Register access is through a simple single-cycle write strobe with an address and data. Read data is combinational from the same address.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the control register, all six alarm field registers and the pending flag read as zero, and `alarm_irq` is low.
- R2: Writes are masked per register. Address 1 (second) and address 2 (minute) keep bits [6:0]. Address 3 (hour) and address 4 (day) keep bits [5:0]. Address 5 (month) keeps bits [4:0]. Address 6 (year) keeps bits [11:0]. The control register at address 0 keeps bits [6:0]. All other bits read back as zero.
- R3: Control bits 0 through 5 enable comparison of second, minute, hour, day, month and year, in that order. A field whose enable bit is clear never causes a fire, even when it matches.
- R4: Control bit 6 is the master enable. While it is clear, no comparison fires, whatever the field enables and the field values.
- R5: The alarm fires when at least one enabled field equals its current calendar value. The other enabled fields need not match.
- R6: The year comparison uses all 12 bits (three BCD digits). Equal low digits with a different hundreds digit is not a match.
- R7: A fire in the cycle where `sec_tick` is high sets bit 1 of the pending register (address 7) and drives `alarm_irq` high from the following clock edge.
- R8: Writing to address 7 with bit 1 set clears the pending flag and drops `alarm_irq` after that edge. Writing with bit 1 clear leaves the flag unchanged.
- R9: `alarm_irq` is level-sensitive. Once set, it stays high through later seconds that do not match, until software clears it.
- R10: Comparison happens only in cycles where `sec_tick` is high. Matching fields without a strobe never set the flag.
- R11: When a fire and a clearing write to address 7 happen in the same cycle, the fire wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe for each one-second calendar update |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1 to 6 alarm fields, 7 pending |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| alarm_irq | output | 1 | Level alarm interrupt |

## Verification
The hardest case to reach is a fire that lands in the same cycle as a clearing write to the pending register. The bench reaches it by raising `sec_tick` with a matching field and driving the clearing write in one shared negative-edge slot, then checks that the flag survives. The OR-versus-AND behaviour and the per-field enables also need care. For each field in turn, the bench first fires with only that field enabled and matching. It then fires with that field matching but disabled while a different enabled field mismatches, and expects no interrupt.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int NUM_FIELDS  = 6;
    localparam int FIELD_MAX_W = 12;
    localparam int CTRL_W      = NUM_FIELDS + 1;
    localparam int ADDR_W      = 3;
    localparam int PEND_BIT    = 1;

    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 6;
    localparam int MON_W  = 5;
    localparam int YEAR_W = 12;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_SEC  = 3'd1,
        A_MIN  = 3'd2,
        A_HOUR = 3'd3,
        A_DAY  = 3'd4,
        A_MON  = 3'd5,
        A_YEAR = 3'd6,
        A_PEND = 3'd7
    } reg_addr_e;

    typedef logic [FIELD_MAX_W-1:0]                 field_t;
    typedef logic [NUM_FIELDS-1:0][FIELD_MAX_W-1:0] field_vec_t;

    typedef struct packed {
        logic                  master_en;
        logic [NUM_FIELDS-1:0] field_en;
    } alarm_ctrl_t;

    function automatic int field_width(input int idx);
        case (idx)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return HOUR_W;
            3:       return DAY_W;
            4:       return MON_W;
            default: return YEAR_W;
        endcase
    endfunction

    function automatic field_t field_mask(input int idx);
        field_t m;
        for (int b = 0; b < FIELD_MAX_W; b++) begin
            m[b] = (b < field_width(idx));
        end
        return m;
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output alarm_ctrl_t       ctrl,
    output field_vec_t        alarm
);

    alarm_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == A_CTRL) begin
            ctrl_q <= alarm_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    assign ctrl = ctrl_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
        localparam field_t            MY_MASK = field_mask(i);
        field_t val_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (wr_en && addr == MY_ADDR) begin
                val_q <= wdata[FIELD_MAX_W-1:0] & MY_MASK;
            end
        end

        assign alarm[i] = val_q;
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_alarm_pkg::*;
(
    input  logic        tick,
    input  alarm_ctrl_t ctrl,
    input  field_vec_t  alarm,
    input  field_vec_t  cur,
    output logic        hit
);

    logic [NUM_FIELDS-1:0] eq;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign eq[i] = ctrl.field_en[i] && (alarm[i] == cur[i]);
    end

    assign hit = tick && ctrl.master_en && (|eq);

endmodule

// File: rtl/cal_alarm_pending.sv
module cal_alarm_pending (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
    import cal_alarm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic [MON_W-1:0]  cur_mon,
    input  logic [YEAR_W-1:0] cur_year,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    alarm_ctrl_t ctrl_q;
    field_vec_t  alarm_q;
    field_vec_t  cur_vec;
    logic        match_hit;
    logic        pend_clr;
    logic        pend_flag;

    assign cur_vec[0] = FIELD_MAX_W'(cur_sec);
    assign cur_vec[1] = FIELD_MAX_W'(cur_min);
    assign cur_vec[2] = FIELD_MAX_W'(cur_hour);
    assign cur_vec[3] = FIELD_MAX_W'(cur_day);
    assign cur_vec[4] = FIELD_MAX_W'(cur_mon);
    assign cur_vec[5] = FIELD_MAX_W'(cur_year);

    cal_alarm_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .ctrl  (ctrl_q),
        .alarm (alarm_q)
    );

    cal_alarm_match u_match (
        .tick  (sec_tick),
        .ctrl  (ctrl_q),
        .alarm (alarm_q),
        .cur   (cur_vec),
        .hit   (match_hit)
    );

    assign pend_clr = bus_wr && (bus_addr == A_PEND) && bus_wdata[PEND_BIT];

    cal_alarm_pending u_pend (
        .clk   (clk),
        .rst   (rst),
        .set_i (match_hit),
        .clr_i (pend_clr),
        .flag  (pend_flag)
    );

    assign alarm_irq = pend_flag;

    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            A_CTRL: bus_rdata[CTRL_W-1:0]      = ctrl_q;
            A_SEC:  bus_rdata[FIELD_MAX_W-1:0] = alarm_q[0];
            A_MIN:  bus_rdata[FIELD_MAX_W-1:0] = alarm_q[1];
            A_HOUR: bus_rdata[FIELD_MAX_W-1:0] = alarm_q[2];
            A_DAY:  bus_rdata[FIELD_MAX_W-1:0] = alarm_q[3];
            A_MON:  bus_rdata[FIELD_MAX_W-1:0] = alarm_q[4];
            A_YEAR: bus_rdata[FIELD_MAX_W-1:0] = alarm_q[5];
            A_PEND: bus_rdata[PEND_BIT]        = pend_flag;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_alarm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              alarm_irq,
    input logic              hit,
    input logic              master_en
);

    logic clr_wr;
    assign clr_wr = bus_wr && (bus_addr == A_PEND) && bus_wdata[PEND_BIT];

    // R10
    irq_rise_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_irq) |-> $past(sec_tick));

    // R4
    hit_needs_master_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (master_en && sec_tick));

    // R7
    hit_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_irq);

    // R8
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !hit) |=> !alarm_irq);

    // R9
    irq_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_irq && !clr_wr) |=> alarm_irq);

endmodule

bind cal_alarm_top cal_alarm_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .alarm_irq (alarm_irq),
    .hit       (match_hit),
    .master_en (ctrl_q.master_en)
);

// File: tb/cal_alarm_top_tb.sv
module cal_alarm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic [11:0] cur_v [6];
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cal_alarm_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .cur_sec   (cur_v[0][6:0]),
        .cur_min   (cur_v[1][6:0]),
        .cur_hour  (cur_v[2][5:0]),
        .cur_day   (cur_v[3][5:0]),
        .cur_mon   (cur_v[4][4:0]),
        .cur_year  (cur_v[5]),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .alarm_irq (alarm_irq)
    );

    // alarm values used per field, and non-matching calendar values
    function automatic logic [11:0] alarm_val(input int i);
        case (i)
            0: return 12'h012;
            1: return 12'h034;
            2: return 12'h021;
            3: return 12'h015;
            4: return 12'h009;
            default: return 12'h234;
        endcase
    endfunction

    function automatic logic [11:0] idle_val(input int i);
        case (i)
            0: return 12'h045;
            1: return 12'h007;
            2: return 12'h003;
            3: return 12'h028;
            4: return 12'h011;
            default: return 12'h099;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sec_tick = 1'b0;
        bus_wr = 1'b0;
        for (int i = 0; i < 6; i++) cur_v[i] = idle_val(i);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // one-cycle strobe; flag visible from the next negedge
    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq", {31'b0, alarm_irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg", d, 32'h0);
        end
    endtask

    task automatic t_mask();
        logic [31:0] d;
        logic [31:0] exp [7] = '{32'h7F, 32'h7F, 32'h7F, 32'h3F, 32'h3F, 32'h1F, 32'hFFF};
        do_reset();
        for (int a = 0; a < 7; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), d);
            check("R2 mask", d, exp[a]);
        end
    endtask

    task automatic t_field_enables();
        logic [31:0] d;
        for (int i = 0; i < 6; i++) begin
            int j = (i + 1) % 6;
            do_reset();
            wr(3'(i + 1), 32'(alarm_val(i)));
            wr(3'd0, 32'h40 | (32'h1 << i));
            cur_v[i] = alarm_val(i);
            tick();
            check("R3 enabled field fires", {31'b0, alarm_irq}, 32'h1);
            rd(3'd7, d);
            check("R7 pending bit1", d, 32'h2);
            wr(3'd7, 32'h2);
            // field i still matches but is disabled; enabled field j mismatches
            wr(3'd0, 32'h40 | (32'h1 << j));
            tick();
            check("R3 disabled field ignored", {31'b0, alarm_irq}, 32'h0);
        end
    endtask

    task automatic t_master();
        do_reset();
        for (int i = 0; i < 6; i++) begin
            wr(3'(i + 1), 32'(alarm_val(i)));
            cur_v[i] = alarm_val(i);
        end
        wr(3'd0, 32'h3F);
        tick();
        tick();
        check("R4 master off", {31'b0, alarm_irq}, 32'h0);
        wr(3'd0, 32'h7F);
        tick();
        check("R4 master on", {31'b0, alarm_irq}, 32'h1);
    endtask

    task automatic t_or();
        do_reset();
        wr(3'd1, 32'(alarm_val(0)));
        wr(3'd2, 32'(alarm_val(1)));
        wr(3'd0, 32'h43);
        cur_v[0] = alarm_val(0);
        tick();
        check("R5 one of two matches", {31'b0, alarm_irq}, 32'h1);
    endtask

    task automatic t_year();
        do_reset();
        wr(3'd6, 32'h123);
        wr(3'd0, 32'h60);
        cur_v[5] = 12'h023;
        tick();
        check("R6 hundreds differ", {31'b0, alarm_irq}, 32'h0);
        cur_v[5] = 12'h123;
        tick();
        check("R6 full year match", {31'b0, alarm_irq}, 32'h1);
    endtask

    task automatic t_no_tick();
        do_reset();
        wr(3'd1, 32'h012);
        wr(3'd0, 32'h41);
        cur_v[0] = 12'h012;
        repeat (5) @(negedge clk);
        check("R10 no strobe", {31'b0, alarm_irq}, 32'h0);
    endtask

    task automatic t_w1c_level();
        logic [31:0] d;
        do_reset();
        wr(3'd2, 32'h034);
        wr(3'd0, 32'h42);
        cur_v[1] = 12'h034;
        tick();
        cur_v[1] = 12'h035;
        tick();
        tick();
        check("R9 level holds", {31'b0, alarm_irq}, 32'h1);
        wr(3'd7, 32'hFFFF_FFFD);
        rd(3'd7, d);
        check("R8 write zero keeps", d, 32'h2);
        wr(3'd7, 32'h2);
        check("R8 w1c irq", {31'b0, alarm_irq}, 32'h0);
        rd(3'd7, d);
        check("R8 w1c pending", d, 32'h0);
    endtask

    task automatic t_collide();
        do_reset();
        wr(3'd1, 32'h012);
        wr(3'd0, 32'h41);
        cur_v[0] = 12'h012;
        tick();
        @(negedge clk);
        sec_tick = 1'b1;
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 32'h2;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_wr = 1'b0; bus_wdata = '0;
        check("R11 set wins", {31'b0, alarm_irq}, 32'h1);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) cur_v[i] = idle_val(i);
        t_reset();
        t_mask();
        t_field_enables();
        t_master();
        t_or();
        t_year();
        t_no_tick();
        t_w1c_level();
        t_collide();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule